// File: doc/BRIEF.md
# Privileged Status Register and Stack Pointer Bank

This block holds the 16-bit status register of a processor core together with two banked 32-bit stack pointers, one for user code and one for the supervisor. The supervisor bit of the status register chooses which pointer the architectural A7 reads and writes. The core's datapath sends one request per cycle, with an operation code and an operand. The request can replace the whole status register, combine it with an immediate by AND, OR or XOR, update only the condition-code bits, or move the user stack pointer to or from a general register.

Requests that need privilege are refused in user mode. A refused request changes no state. The block reports the refusal in the same cycle through a violation flag and the vector number 8, which the exception sequencer uses. Status register updates are registered. They take effect on the clock edge that accepts them, so the A7 access in the following cycle already uses the newly selected pointer.

Top module: `sr_stack_bank`

## Requirements
- R1: When reset is asserted, the status register reads 0x2700. Neither stack pointer is changed by reset.
- R2: The implemented status register bits are:
  - bit 15: trace;
  - bit 13: supervisor;
  - bits 10..8: interrupt mask;
  - bits 4..0: the condition codes X, N, Z, V, C.
  Bits 14, 12, 11, 7, 6 and 5 always read 0, whatever value is written.
- R3: Request codes on `req_op` are: 0 none, 1 move to SR, 2 AND SR, 3 OR SR, 4 XOR SR, 5 CCR write, 6 USP to register, 7 register to USP. In supervisor mode, code 1 loads `req_data` into the status register, with the unimplemented bits masked to 0.
- R4: In supervisor mode, codes 2, 3 and 4 combine the status register with `req_data` by AND, OR and XOR. An AND with 0x7FFF clears only the trace bit.
- R5: Code 5 is accepted in both modes. It changes only bits 4..0 and never raises a violation.
- R6: `a7_rdata` shows the supervisor pointer when bit 13 is 1 and the user pointer when it is 0. An `a7_we` write goes to the pointer selected in that cycle.
- R7: In supervisor mode, code 7 loads all 32 bits of `req_gpr` into the user pointer. Code 6 presents all 32 bits of the user pointer on `usp_rdata` with `usp_rvalid` high.
- R8: When bit 13 is 0, codes 1, 2, 3, 4, 6 and 7 raise `priv_viol` in the same cycle with `viol_vector` equal to 8. They also leave the status register and the user pointer unchanged and keep `usp_rvalid` low.
- R9: A status register write that clears bit 13 switches A7 to the user pointer from the next cycle. An A7 write in the same cycle still goes to the supervisor pointer.
- R10: When there is no request, or the request is accepted, `priv_viol` is 0 and `viol_vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Request code (see R3) |
| req_data | input | 16 | Status register operand |
| req_gpr | input | 32 | General register value for a user pointer load |
| a7_we | input | 1 | Write the active stack pointer |
| a7_wdata | input | 32 | Value for the active stack pointer |
| a7_rdata | output | 32 | Active stack pointer |
| sr_out | output | 16 | Status register |
| usp_rdata | output | 32 | User stack pointer for a transfer to a register |
| usp_rvalid | output | 1 | `usp_rdata` belongs to an accepted code-6 request |
| priv_viol | output | 1 | Request refused for lack of privilege |
| viol_vector | output | 8 | Exception vector for the refusal, 8 when refused |

## Verification
An A7 write and a status register write that clears the supervisor bit can fall in the same cycle. The bench provokes this by issuing a move to SR with bit 13 at 0 together with an `a7_we` write. It then judges the result through the ports. The written value must appear on `a7_rdata` only after the mode returns to supervisor, after a reset, and the A7 read in the next cycle must show the earlier user pointer. A second coincidence is checked in user mode: an A7 write together with a refused user pointer load. Here the bench checks that the A7 value wins and that the refused load leaves no trace.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_SR_MOVE = 3'd1,
    OP_SR_AND  = 3'd2,
    OP_SR_OR   = 3'd3,
    OP_SR_XOR  = 3'd4,
    OP_CCR_WR  = 3'd5,
    OP_USP_RD  = 3'd6,
    OP_USP_WR  = 3'd7
  } sr_op_e;

  localparam int SR_W      = 16;
  localparam int SR_S_BIT  = 13;
  localparam int SR_T_BIT  = 15;
  localparam logic [SR_W-1:0] SR_IMPL_MASK = 16'hA71F;
  localparam logic [SR_W-1:0] SR_CC_MASK   = 16'h001F;

  function automatic logic op_needs_priv(input sr_op_e op);
    return (op != OP_NONE) && (op != OP_CCR_WR);
  endfunction
endpackage

// File: rtl/sr_priv_gate.sv
module sr_priv_gate
  import sr_pkg::*;
(
  input  logic   req_valid,
  input  sr_op_e req_op,
  input  logic   super_mode,
  output logic   sr_wr_en,
  output logic   ccr_wr_en,
  output logic   usp_wr_en,
  output logic   usp_rd_en,
  output logic   viol
);
  logic priv_ok;

  always_comb begin
    priv_ok   = super_mode || !op_needs_priv(req_op);
    viol      = req_valid && !priv_ok;
    sr_wr_en  = 1'b0;
    ccr_wr_en = 1'b0;
    usp_wr_en = 1'b0;
    usp_rd_en = 1'b0;
    if (req_valid && priv_ok) begin
      unique case (req_op)
        OP_SR_MOVE, OP_SR_AND, OP_SR_OR, OP_SR_XOR: sr_wr_en = 1'b1;
        OP_CCR_WR: ccr_wr_en = 1'b1;
        OP_USP_WR: usp_wr_en = 1'b1;
        OP_USP_RD: usp_rd_en = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sr_reg.sv
module sr_reg
  import sr_pkg::*;
#(
  parameter logic [SR_W-1:0] RESET_VAL = 16'h2700
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_wr_en,
  input  logic            ccr_wr_en,
  input  sr_op_e          op,
  input  logic [SR_W-1:0] operand,
  output logic [SR_W-1:0] sr_q
);
  logic [SR_W-1:0] sr_d;
  logic [SR_W-1:0] combined;

  always_comb begin
    unique case (op)
      OP_SR_AND: combined = sr_q & operand;
      OP_SR_OR:  combined = sr_q | operand;
      OP_SR_XOR: combined = sr_q ^ operand;
      default:   combined = operand;
    endcase
    sr_d = sr_q;
    if (sr_wr_en)
      sr_d = combined & SR_IMPL_MASK;
    else if (ccr_wr_en)
      sr_d = (sr_q & ~SR_CC_MASK) | (operand & SR_CC_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= RESET_VAL & SR_IMPL_MASK;
    else if (sr_wr_en || ccr_wr_en)
      sr_q <= sr_d;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q & ~SR_IMPL_MASK) == '0);
  assert_ccr_only_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_wr_en |=> $stable(sr_q[SR_W-1:5]));
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_wr_en || ccr_wr_en) |=> $stable(sr_q));
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int SP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            super_sel,
  input  logic            a7_we,
  input  logic [SP_W-1:0] a7_wdata,
  input  logic            usp_wr_en,
  input  logic [SP_W-1:0] usp_wdata,
  output logic [SP_W-1:0] a7_rdata,
  output logic [SP_W-1:0] usp_q
);
  logic [SP_W-1:0] ssp_q;
  logic            ssp_en, usp_en;
  logic [SP_W-1:0] usp_d;

  always_comb begin
    ssp_en   = a7_we && super_sel;
    usp_en   = (a7_we && !super_sel) || usp_wr_en;
    usp_d    = usp_wr_en ? usp_wdata : a7_wdata;
    a7_rdata = super_sel ? ssp_q : usp_q;
  end

  always_ff @(posedge clk) begin
    if (ssp_en) ssp_q <= a7_wdata;
    if (usp_en) usp_q <= usp_d;
  end

  assert_user_a7_spares_ssp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a7_we && !super_sel) |=> $stable(ssp_q));
  assert_no_usp_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(usp_wr_en && a7_we && !super_sel));
endmodule

// File: rtl/sr_stack_bank.sv
module sr_stack_bank
  import sr_pkg::*;
#(
  parameter int              SP_W      = 32,
  parameter int              VEC_W     = 8,
  parameter logic [VEC_W-1:0] PRIV_VEC = 8'd8,
  parameter logic [15:0]     SR_RESET  = 16'h2700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [15:0]      req_data,
  input  logic [SP_W-1:0]  req_gpr,
  input  logic             a7_we,
  input  logic [SP_W-1:0]  a7_wdata,
  output logic [SP_W-1:0]  a7_rdata,
  output logic [15:0]      sr_out,
  output logic [SP_W-1:0]  usp_rdata,
  output logic             usp_rvalid,
  output logic             priv_viol,
  output logic [VEC_W-1:0] viol_vector
);
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  sr_op_e op;
  logic   sr_wr_en, ccr_wr_en, usp_wr_en, usp_rd_en, viol;
  logic [SR_W-1:0] sr_q;

  assign op = sr_op_e'(req_op);

  sr_priv_gate u_gate (
    .req_valid (req_valid),
    .req_op    (op),
    .super_mode(sr_q[SR_S_BIT]),
    .sr_wr_en  (sr_wr_en),
    .ccr_wr_en (ccr_wr_en),
    .usp_wr_en (usp_wr_en),
    .usp_rd_en (usp_rd_en),
    .viol      (viol)
  );

  sr_reg #(.RESET_VAL(SR_RESET)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sr_wr_en (sr_wr_en),
    .ccr_wr_en(ccr_wr_en),
    .op       (op),
    .operand  (req_data),
    .sr_q     (sr_q)
  );

  sp_bank #(.SP_W(SP_W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .super_sel(sr_q[SR_S_BIT]),
    .a7_we    (a7_we),
    .a7_wdata (a7_wdata),
    .usp_wr_en(usp_wr_en),
    .usp_wdata(req_gpr),
    .a7_rdata (a7_rdata),
    .usp_q    (usp_rdata)
  );

  assign sr_out      = sr_q;
  assign usp_rvalid  = usp_rd_en;
  assign priv_viol   = viol;
  assign viol_vector = viol ? PRIV_VEC : '0;

  assert_viol_vector_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    priv_viol |-> (viol_vector == 8'd8 && !usp_rvalid));
  assert_viol_keeps_sr_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    priv_viol |=> $stable(sr_out));
  assert_viol_only_user_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    priv_viol |-> !sr_out[SR_S_BIT]);
  assert_ccr_never_viol_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && req_op == 3'd5) |-> !priv_viol);
  assert_user_load_refused_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && req_op == 3'd7 && !sr_out[SR_S_BIT] && !a7_we) |=> $stable(usp_rdata));
  assert_no_req_no_viol_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    !req_valid |-> (!priv_viol && viol_vector == '0));
endmodule

// File: tb/sr_stack_bank_bench.sv
`timescale 1ns/1ps
module sr_stack_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [15:0] req_data;
  logic [31:0] req_gpr;
  logic        a7_we;
  logic [31:0] a7_wdata;
  logic [31:0] a7_rdata, usp_rdata;
  logic [15:0] sr_out;
  logic        usp_rvalid, priv_viol;
  logic [7:0]  viol_vector;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  sr_stack_bank u_sr_stack_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .req_gpr(req_gpr), .a7_we(a7_we), .a7_wdata(a7_wdata),
    .a7_rdata(a7_rdata), .sr_out(sr_out), .usp_rdata(usp_rdata),
    .usp_rvalid(usp_rvalid), .priv_viol(priv_viol), .viol_vector(viol_vector)
  );

  // {op, operand, expected SR after, expected violation}
  localparam int NV = 12;
  localparam logic [35:0] VECS [NV] = '{
    {3'd1, 16'hFFFF, 16'hA71F, 1'b0},  // R3 R2
    {3'd2, 16'h7FFF, 16'h271F, 1'b0},  // R4 trace off
    {3'd3, 16'h8000, 16'hA71F, 1'b0},  // R4
    {3'd4, 16'h0615, 16'hA10A, 1'b0},  // R4
    {3'd5, 16'hFFE0, 16'hA100, 1'b0},  // R5
    {3'd1, 16'h2504, 16'h2504, 1'b0},  // R3
    {3'd1, 16'h0011, 16'h0011, 1'b0},  // R3 leave supervisor
    {3'd1, 16'h2700, 16'h0011, 1'b1},  // R8
    {3'd3, 16'h2000, 16'h0011, 1'b1},  // R8
    {3'd5, 16'hFFFF, 16'h001F, 1'b0},  // R5 user mode
    {3'd4, 16'h2000, 16'h001F, 1'b1},  // R8
    {3'd2, 16'h0000, 16'h001F, 1'b1}   // R8
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_op = 0; req_data = 0; req_gpr = 0; a7_we = 0; a7_wdata = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; idle();
    #1 check("R1 reset SR", {16'h0, sr_out}, 32'h2700);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  // drive at a negedge, sample combinational outputs shortly after,
  // registered results at the following negedge
  task automatic drive(input logic [2:0] op, input logic [15:0] d, input logic [31:0] g,
                       input logic we, input logic [31:0] wd);
    req_valid = (op != 0); req_op = op; req_data = d; req_gpr = g; a7_we = we; a7_wdata = wd;
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    do_reset();
    check("R1 SR after release", {16'h0, sr_out}, 32'h2700);
    check("R10 no request", {23'h0, priv_viol, viol_vector}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i][35:33], VECS[i][32:17], 32'h0, 1'b0, 32'h0);
      check(VECS[i][0] ? "R8 viol flag" : "R10 viol flag", {31'h0, priv_viol}, {31'h0, VECS[i][0]});
      check(VECS[i][0] ? "R8 vector" : "R10 vector", {24'h0, viol_vector}, VECS[i][0] ? 32'd8 : 32'd0);
      @(negedge clk); idle();
      check("R2 R3 R4 R5 R8 SR", {16'h0, sr_out}, {16'h0, VECS[i][16:1]});
    end

    // stack banking
    do_reset();
    @(negedge clk); drive(3'd0, 0, 0, 1'b1, 32'h0000_8000);
    @(negedge clk); idle(); #1;
    check("R6 A7 is SSP", a7_rdata, 32'h0000_8000);
    @(negedge clk); drive(3'd7, 0, 32'h1234_5678, 1'b0, 0);
    @(negedge clk); idle(); #1;
    check("R7 A7 still SSP", a7_rdata, 32'h0000_8000);
    drive(3'd6, 0, 0, 1'b0, 0);
    check("R7 USP read data", usp_rdata, 32'h1234_5678);
    check("R7 USP read valid", {31'h0, usp_rvalid}, 32'h1);
    // R9: clear S and write A7 in the same cycle
    @(negedge clk); drive(3'd1, 16'h0000, 0, 1'b1, 32'hAAAA_0000);
    @(negedge clk); idle(); #1;
    check("R9 A7 switches to USP", a7_rdata, 32'h1234_5678);
    @(negedge clk); drive(3'd0, 0, 0, 1'b1, 32'h0000_5554);
    @(negedge clk); idle(); #1;
    check("R6 user A7 write", a7_rdata, 32'h0000_5554);
    // R8: refused USP load coinciding with user A7 write
    @(negedge clk); drive(3'd7, 0, 32'hDEAD_BEEF, 1'b1, 32'h0000_4000);
    check("R8 USP load refused", {24'h0, viol_vector}, 32'd8);
    @(negedge clk); idle(); #1;
    check("R8 USP unchanged by refusal", a7_rdata, 32'h0000_4000);
    drive(3'd6, 0, 0, 1'b0, 0);
    check("R8 USP read refused", {30'h0, usp_rvalid, priv_viol}, 32'h1);
    // reset: SR back to supervisor, SSP kept the value written during R9 cycle
    do_reset();
    check("R9 R1 SSP got coincident write", a7_rdata, 32'hAAAA_0000);
    @(negedge clk); drive(3'd6, 0, 0, 1'b0, 0);
    check("R1 USP kept over reset", usp_rdata, 32'h0000_4000);
    @(negedge clk); idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule